// File: doc/BRIEF.md
# History-Based Program Type Classifier

This block keeps, for each of a small number of program slots, a record of how long the program took to run under each of four L2 cache settings: full capacity, half capacity, quarter capacity, and bypass (no L2). Each time a program is about to run, the caller pulses a start strobe with the program index. The block answers with the L2 setting to use for that run. While the history is incomplete, the answer is the next unrecorded setting in a fixed sequence. When the run finishes, the caller pulses a done strobe with the measured cycle count, and the block stores it in the matching slot.

Once all four settings have a recorded time, the block classifies the program. The classification compares each time against the full-capacity time by ratio thresholds, computed without division. From then on the block reports the program's type and the fixed L2 setting for that type. It also reports a multicore bypass decision. For programs of the middle type, that decision depends on a memory-intensity product built from the L1 data miss count and the committed instruction count supplied with the start strobe.

Top module: `prog_type_classifier`

## Requirements
- R1: After reset every output is zero: `cfg_o`=0, `type_o`=0, `valid_o`=0, `mc_bypass_o`=0.
- R2: `cfg_o` encodes 0=full, 1=half, 2=quarter, 3=bypass. For an unclassified program, the start strobe reports the next unrecorded setting in the order 0,1,2,3. A program with no history therefore gets 0.
- R3: A program becomes classified only when its fourth time is recorded. Until then, a start reports `valid_o`=0, `type_o`=0 and `mc_bypass_o`=0.
- R4: With t0 the full-capacity time, a time t is in band when 10·t ≤ 11·t0. When the half, quarter and bypass times are all in band, the type is 1. Equality counts as in band.
- R5: When the half and quarter times are in band and the bypass time is not, the type is 2.
- R6: Any other pattern, such as a half-capacity time out of band, gives type 3.
- R7: A time shorter than t0 counts as in band.
- R8: A start for a classified program reports `valid_o`=1 with `cfg_o`=3 for type 1, 2 for type 2 and 0 for type 3.
- R9: For a classified program, `mc_bypass_o` is 1 for type 1 and 0 for type 3.
- R10: For type 2, `mc_bypass_o` is 0 when 200·`miss_i` > `instr_i`, and 1 otherwise, including when the two are equal.
- R11: A done strobe for a classified program changes nothing: a later start reports the same type and setting.
- R12: `clear_i` returns the entry `prog_i` to the no-history state. Other entries keep their history.
- R13: Outputs change only in the cycle after a start strobe. Without a start they hold, even when `prog_i` changes.
- R14: Entries are independent: interleaved runs of different programs each advance only their own history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_i | input | 3 | Program entry index |
| start_i | input | 1 | Run-start strobe; loads the outputs for `prog_i` |
| done_i | input | 1 | Run-done strobe; records `time_i` for `prog_i` |
| time_i | input | 32 | Measured run time in cycles |
| clear_i | input | 1 | Clears the history of entry `prog_i` |
| miss_i | input | 32 | L1 data miss count, used with start |
| instr_i | input | 32 | Committed instruction count, used with start |
| cfg_o | output | 2 | L2 setting for the run |
| type_o | output | 2 | Program type, 0 while unclassified |
| valid_o | output | 1 | Program is classified |
| mc_bypass_o | output | 1 | Bypass L2 when several programs run together |

## Verification
On every cycle, the assertions check the output-level relations:
- An unclassified answer carries no type and no bypass.
- A classified answer carries a nonzero type with its matching setting.
- Type 1 always bypasses and type 3 never does.
- Outputs hold between start strobes.

The band thresholds and their equality edges, the fill order of the history, the intensity boundary, the ignored late done strobes, and the clearing and independence of entries depend on stored history. Only the bench's directed scenarios, which replay full run sequences, can show those.

// File: rtl/prog_cls_pkg.sv
package prog_cls_pkg;
  localparam int NUM_CFG = 4;

  typedef enum logic [1:0] {
    CFG_FULL    = 2'd0,
    CFG_HALF    = 2'd1,
    CFG_QUARTER = 2'd2,
    CFG_BYPASS  = 2'd3
  } l2_cfg_e;

  typedef enum logic [1:0] {
    TYPE_NONE  = 2'd0,
    TYPE_SMALL = 2'd1,
    TYPE_MID   = 2'd2,
    TYPE_LARGE = 2'd3
  } prog_type_e;

  function automatic l2_cfg_e type_to_cfg(prog_type_e t);
    case (t)
      TYPE_SMALL: return CFG_BYPASS;
      TYPE_MID:   return CFG_QUARTER;
      default:    return CFG_FULL;
    endcase
  endfunction
endpackage

// File: rtl/prog_hist_table.sv
module prog_hist_table
  import prog_cls_pkg::*;
#(
  parameter int N_PROG = 8,
  parameter int TIME_W = 32,
  localparam int IDX_W = $clog2(N_PROG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [TIME_W-1:0] time_i,
  input  prog_type_e        new_type_i,
  output logic [TIME_W-1:0] slot_o [NUM_CFG],
  output logic [1:0]        ptr_o,
  output logic              cls_o,
  output prog_type_e        type_o
);
  logic [TIME_W-1:0] slot_q [N_PROG][NUM_CFG];
  logic [1:0]        ptr_q  [N_PROG];
  logic              cls_q  [N_PROG];
  prog_type_e        type_q [N_PROG];

  for (genvar g = 0; g < N_PROG; g++) begin : g_entry
    logic sel, wr;
    assign sel = (idx_i == IDX_W'(g));
    assign wr  = sel & wr_i & ~clr_i & ~cls_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g]  <= '0;
        cls_q[g]  <= 1'b0;
        type_q[g] <= TYPE_NONE;
      end else if (sel && clr_i) begin
        ptr_q[g]  <= '0;
        cls_q[g]  <= 1'b0;
        type_q[g] <= TYPE_NONE;
      end else if (wr) begin
        ptr_q[g] <= ptr_q[g] + 2'd1;
        if (ptr_q[g] == 2'(NUM_CFG - 1)) begin
          cls_q[g]  <= 1'b1;
          type_q[g] <= new_type_i;
        end
      end
    end

    for (genvar c = 0; c < NUM_CFG; c++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              slot_q[g][c] <= '0;
        else if (wr && ptr_q[g] == 2'(c))         slot_q[g][c] <= time_i;
      end
    end
  end

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_rd
    assign slot_o[c] = slot_q[idx_i][c];
  end
  assign ptr_o  = ptr_q[idx_i];
  assign cls_o  = cls_q[idx_i];
  assign type_o = type_q[idx_i];
endmodule

// File: rtl/prog_type_decider.sv
module prog_type_decider
  import prog_cls_pkg::*;
#(
  parameter int TIME_W = 32,
  localparam int EXT_W = TIME_W + 4
) (
  input  logic [TIME_W-1:0] t_i [NUM_CFG],
  output prog_type_e        type_o
);
  localparam logic [EXT_W-1:0] NUM = EXT_W'(11);
  localparam logic [EXT_W-1:0] DEN = EXT_W'(10);

  logic [EXT_W-1:0] lim;
  logic [NUM_CFG-1:1] in_band;

  assign lim = EXT_W'(t_i[0]) * NUM;

  // ratio t/t_full <= 1.1 without division; shorter times pass too
  for (genvar k = 1; k < NUM_CFG; k++) begin : g_band
    assign in_band[k] = (EXT_W'(t_i[k]) * DEN) <= lim;
  end

  always_comb begin
    if (&in_band)                       type_o = TYPE_SMALL;
    else if (in_band[1] && in_band[2])  type_o = TYPE_MID;
    else                                type_o = TYPE_LARGE;
  end
endmodule

// File: rtl/prog_mc_policy.sv
module prog_mc_policy
  import prog_cls_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int EXT_W = CNT_W + 8
) (
  input  prog_type_e       type_i,
  input  logic [CNT_W-1:0] miss_i,
  input  logic [CNT_W-1:0] instr_i,
  output logic             bypass_o
);
  localparam logic [EXT_W-1:0] SCALE = EXT_W'(200);
  logic heavy;

  // miss/instr > 0.005  <=>  200*miss > instr
  assign heavy    = (EXT_W'(miss_i) * SCALE) > EXT_W'(instr_i);
  assign bypass_o = (type_i == TYPE_SMALL) || ((type_i == TYPE_MID) && !heavy);
endmodule

// File: rtl/prog_type_classifier.sv
module prog_type_classifier
  import prog_cls_pkg::*;
#(
  parameter int N_PROG = 8,
  parameter int TIME_W = 32,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(N_PROG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  prog_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  miss_i,
  input  logic [CNT_W-1:0]  instr_i,
  output logic [1:0]        cfg_o,
  output logic [1:0]        type_o,
  output logic              valid_o,
  output logic              mc_bypass_o
);
  logic [TIME_W-1:0] slot [NUM_CFG];
  logic [TIME_W-1:0] dec_t [NUM_CFG];
  logic [1:0]        ptr;
  logic              cls;
  prog_type_e        ent_type, new_type;
  logic              pol_bypass;

  prog_hist_table #(.N_PROG(N_PROG), .TIME_W(TIME_W)) u_table (
    .clk_i, .rst_ni,
    .idx_i(prog_i), .clr_i(clear_i), .wr_i(done_i), .time_i,
    .new_type_i(new_type),
    .slot_o(slot), .ptr_o(ptr), .cls_o(cls), .type_o(ent_type)
  );

  // last slot comes straight from the completing run
  for (genvar c = 0; c < NUM_CFG; c++) begin : g_dec
    if (c == NUM_CFG - 1) begin : g_new
      assign dec_t[c] = time_i;
    end else begin : g_old
      assign dec_t[c] = slot[c];
    end
  end

  prog_type_decider #(.TIME_W(TIME_W)) u_decide (
    .t_i(dec_t), .type_o(new_type)
  );

  prog_mc_policy #(.CNT_W(CNT_W)) u_policy (
    .type_i(ent_type), .miss_i, .instr_i, .bypass_o(pol_bypass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o       <= CFG_FULL;
      type_o      <= TYPE_NONE;
      valid_o     <= 1'b0;
      mc_bypass_o <= 1'b0;
    end else if (start_i) begin
      if (cls) begin
        cfg_o       <= type_to_cfg(ent_type);
        type_o      <= ent_type;
        valid_o     <= 1'b1;
        mc_bypass_o <= pol_bypass;
      end else begin
        cfg_o       <= ptr;
        type_o      <= TYPE_NONE;
        valid_o     <= 1'b0;
        mc_bypass_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_type_classifier_chk.sv
module prog_type_classifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] cfg_o,
  input logic [1:0] type_o,
  input logic       valid_o,
  input logic       mc_bypass_o
);
  AST_UNCLS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (type_o == 2'd0 && !mc_bypass_o)); // R3
  AST_CLS_TYPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (type_o != 2'd0)); // R3
  AST_CFG_OF_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((type_o == 2'd1 && cfg_o == 2'd3) || (type_o == 2'd2 && cfg_o == 2'd2)
                 || (type_o == 2'd3 && cfg_o == 2'd0))); // R8
  AST_SMALL_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && type_o == 2'd1) |-> mc_bypass_o); // R9
  AST_LARGE_NOBYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && type_o == 2'd3) |-> !mc_bypass_o); // R9
  AST_HOLD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(cfg_o) && $stable(type_o) && $stable(valid_o)
                  && $stable(mc_bypass_o))); // R13
endmodule

bind prog_type_classifier prog_type_classifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_o(cfg_o),
  .type_o(type_o), .valid_o(valid_o), .mc_bypass_o(mc_bypass_o)
);

// File: tb/prog_type_classifier_tb_top.sv
module prog_type_classifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  prog_i = '0;
  logic        start_i = 1'b0, done_i = 1'b0, clear_i = 1'b0;
  logic [31:0] time_i = '0, miss_i = '0, instr_i = 32'd1;
  logic [1:0]  cfg_o, type_o;
  logic        valid_o, mc_bypass_o;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_type_classifier dut_i (
    .clk_i(clk), .rst_ni, .prog_i, .start_i, .done_i, .time_i, .clear_i,
    .miss_i, .instr_i, .cfg_o, .type_o, .valid_o, .mc_bypass_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(int p, int miss, int instr);
    @(negedge clk);
    prog_i = 3'(p); miss_i = miss; instr_i = instr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_done(int p, int t);
    @(negedge clk);
    prog_i = 3'(p); time_i = t; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic do_clear(int p);
    @(negedge clk);
    prog_i = 3'(p); clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  // fill four slots, checking the tried setting before each run
  task automatic train(int p, int t0, int t1, int t2, int t3);
    int t [4];
    t = '{t0, t1, t2, t3};
    for (int k = 0; k < 4; k++) begin
      do_start(p, 0, 1);
      chk("R2", "next cfg", cfg_o, k);
      chk("R3", "valid before 4 runs", valid_o, 0);
      chk("R3", "type before 4 runs", type_o, 0);
      do_done(p, t[k]);
    end
  endtask

  task automatic expect_cls(string req, int p, int miss, int instr, int ty, int cfg, int byp);
    do_start(p, miss, instr);
    chk(req, "valid", valid_o, 1);
    chk(req, "type", type_o, ty);
    chk(req, "cfg", cfg_o, cfg);
    chk(req, "mc bypass", mc_bypass_o, byp);
  endtask

  task automatic t_reset();
    chk("R1", "cfg reset", cfg_o, 0);
    chk("R1", "type reset", type_o, 0);
    chk("R1", "valid reset", valid_o, 0);
    chk("R1", "bypass reset", mc_bypass_o, 0);
  endtask

  task automatic t_small();
    train(0, 1000, 1100, 1050, 1100); // 10*1100 == 11*1000: in band
    expect_cls("R4", 0, 0, 1, 1, 3, 1);
    chk("R9", "type1 bypass", mc_bypass_o, 1);
    chk("R8", "type1 cfg", cfg_o, 3);
  endtask

  task automatic t_mid();
    train(1, 1000, 1000, 1100, 1101);
    expect_cls("R5", 1, 5, 1000, 2, 2, 1);   // 200*5 == 1000: not heavy
    chk("R10", "equal product bypasses", mc_bypass_o, 1);
    expect_cls("R10", 1, 6, 1000, 2, 2, 0);  // 1200 > 1000: heavy
    chk("R8", "type2 cfg", cfg_o, 2);
  endtask

  task automatic t_large();
    train(2, 1000, 1101, 1000, 1000);
    expect_cls("R6", 2, 0, 1, 3, 0, 0);
    chk("R9", "type3 no bypass", mc_bypass_o, 0);
    chk("R8", "type3 cfg", cfg_o, 0);
  endtask

  task automatic t_shorter();
    train(3, 1000, 900, 500, 800);
    expect_cls("R7", 3, 0, 1, 1, 3, 1);
  endtask

  task automatic t_late_done();
    do_done(0, 100000);
    expect_cls("R11", 0, 0, 1, 1, 3, 1);
  endtask

  task automatic t_clear();
    do_clear(2);
    do_start(2, 0, 1);
    chk("R12", "cleared cfg", cfg_o, 0);
    chk("R12", "cleared valid", valid_o, 0);
    chk("R12", "cleared type", type_o, 0);
    expect_cls("R12", 1, 0, 100, 2, 2, 1);
  endtask

  task automatic t_hold();
    do_start(0, 0, 1);
    @(negedge clk); prog_i = 3'd2;
    repeat (3) @(negedge clk);
    chk("R13", "cfg held", cfg_o, 3);
    chk("R13", "valid held", valid_o, 1);
    chk("R13", "type held", type_o, 1);
  endtask

  task automatic t_interleave();
    do_start(4, 0, 1); do_done(4, 500);
    do_start(5, 0, 1);
    chk("R14", "other entry untouched", cfg_o, 0);
    do_done(5, 700);
    do_start(4, 0, 1);
    chk("R14", "entry 4 second run", cfg_o, 1);
    do_done(4, 500);
    do_start(4, 0, 1);
    chk("R14", "entry 4 third run", cfg_o, 2);
    do_start(5, 0, 1);
    chk("R14", "entry 5 second run", cfg_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_mid();
    t_large();
    t_shorter();
    t_late_done();
    t_clear();
    t_hold();
    t_interleave();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule